// File: doc/BRIEF.md
# Serial Audio Port Control Register

This block holds the 16-bit configuration word of a serial audio port. A CPU reaches it over a single-cycle register bus with separate write and read strobes and one enable per byte lane. The bus has no back-pressure: every strobe completes in the cycle it is presented. The stored fields drive plain configuration pins that select the port's mode, word size, slot count, frame-sync source, shape and polarity, and bit-clock source. Three spare control bits are passed straight through.

Two bits of the word are commands, not settings. Writing a 1 to either of them produces a pulse one system clock long. That pulse resets the pointers of the receive FIFO or the transmit FIFO. The command bit then drops back to 0 by itself. A loopback setting steers the serial data seen by the receiver away from the external receive pin and onto the transmitter's own output. The external transmit pin keeps carrying that output the whole time.

Top module: `audio_port_ctrl`

## Requirements
- R1: After reset, every stored bit is 0, every configuration pin is 0 and both clear pulses are low.
- R2: The low byte decodes as follows: bit 0 selects asynchronous mode, bit 1 selects 16-bit words, bit 2 enables loopback, bits 4:3 hold the slot count minus one, bit 5 selects an external frame sync, bit 6 selects the long frame-sync shape and bit 7 selects an external bit clock.
- R3: The high byte decodes as follows: bits 11:10 hold the long frame-sync length code, bit 12 inverts the frame-sync polarity and bits 15:13 are spare control bits. Bits 9 and 8 are the command bits.
- R4: A write whose high-byte enable is set and whose data bit 8 is 1 raises `rx_fifo_clr` for exactly the one cycle after the write edge. During that cycle, bit 8 reads back as 1. From the next cycle on it reads back as 0.
- R5: Bit 9 behaves the same way and drives `tx_fifo_clr`.
- R6: A write with 0 in bit 8 or bit 9 produces no pulse on the matching clear output.
- R7: A write with only the low-byte enable set leaves every high-byte field unchanged and produces no clear pulse, whatever its high data byte holds. A write with only the high-byte enable set leaves the low byte unchanged.
- R8: While loopback is 1, `ser_rx_out` equals `ser_tx_in`. While loopback is 0, `ser_rx_out` equals `ser_rx_pin`.
- R9: `ser_tx_pin` always equals `ser_tx_in`, in loopback and out of it.
- R10: While `bus_rd` is high, `bus_rdata` shows the stored word in the same cycle. While `bus_rd` is low, it shows 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_be | input | 2 | Byte-lane enables (bit 1 = high byte) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, 0 when not reading |
| cfg_async | output | 1 | Asynchronous mode selected |
| cfg_wide | output | 1 | 16-bit word length selected |
| cfg_loop | output | 1 | Loopback enabled |
| cfg_slots | output | 2 | Slots per frame minus one |
| cfg_ext_sync | output | 1 | Frame sync supplied externally |
| cfg_long_sync | output | 1 | Long frame-sync shape |
| cfg_ext_bclk | output | 1 | Bit clock supplied externally |
| cfg_sync_len | output | 2 | Long frame-sync length code |
| cfg_sync_inv | output | 1 | Frame sync active low |
| cfg_aux | output | 3 | Spare control bits |
| rx_fifo_clr | output | 1 | One-cycle receive FIFO pointer reset |
| tx_fifo_clr | output | 1 | One-cycle transmit FIFO pointer reset |
| ser_tx_in | input | 1 | Serial data from the transmit shifter |
| ser_rx_pin | input | 1 | Serial data from the external receive pin |
| ser_tx_pin | output | 1 | Serial data to the external transmit pin |
| ser_rx_out | output | 1 | Serial data to the receive shifter |

## Verification
The register is written with two full-word patterns that are bit-wise complements in most positions. This makes a swapped or stuck field show up on the configuration pins. The command bits are exercised four ways: set alone, set together, written as 0, and presented under a low-byte-only enable. Together these separate a true one-cycle pulse from a level, a missing pulse and a leak through the wrong byte lane. The serial path is driven with the transmit and receive inputs at opposite values, both with loopback on and off, so the receiver's source can be told apart.

// File: rtl/apc_pkg.sv
package apc_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned LANES  = WORD_W / 8;
  localparam int unsigned BIT_CLR_RX = 8;
  localparam int unsigned BIT_CLR_TX = 9;
  localparam logic [WORD_W-1:0] CMD_MASK =
    (WORD_W'(1) << BIT_CLR_RX) | (WORD_W'(1) << BIT_CLR_TX);

  typedef struct packed {
    logic [2:0] aux;
    logic       sync_inv;
    logic [1:0] sync_len;
    logic       clr_tx;
    logic       clr_rx;
    logic       ext_bclk;
    logic       long_sync;
    logic       ext_sync;
    logic [1:0] slots;
    logic       loop_en;
    logic       wide;
    logic       async_mode;
  } apc_word_t;
endpackage

// File: rtl/apc_lane_regs.sv
module apc_lane_regs #(
  parameter int unsigned DATA_W = 16,
  parameter logic [DATA_W-1:0] SELF_CLR = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [DATA_W/8-1:0] be,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   q
);
  localparam int unsigned NLANE = DATA_W / 8;

  logic [NLANE-1:0] lane_hit;
  assign lane_hit = wr ? be : '0;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    localparam int unsigned LN = b / 8;
    if (SELF_CLR[b]) begin : g_cmd
      // command bit: holds a 1 only for the cycle after the write
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[b] <= 1'b0;
        else        q[b] <= lane_hit[LN] & wdata[b];
      end
    end else begin : g_cfg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            q[b] <= 1'b0;
        else if (lane_hit[LN]) q[b] <= wdata[b];
      end
    end
  end
endmodule

// File: rtl/apc_read_port.sv
module apc_read_port #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              rd,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] rdata
);
  always_comb rdata = rd ? word : '0;
endmodule

// File: rtl/apc_loop_mux.sv
module apc_loop_mux (
  input  logic loop_en,
  input  logic tx_in,
  input  logic rx_pin,
  output logic tx_pin,
  output logic rx_out
);
  assign tx_pin = tx_in;
  always_comb rx_out = loop_en ? tx_in : rx_pin;
endmodule

// File: rtl/audio_port_ctrl.sv
module audio_port_ctrl
  import apc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_be,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        cfg_async,
  output logic        cfg_wide,
  output logic        cfg_loop,
  output logic [1:0]  cfg_slots,
  output logic        cfg_ext_sync,
  output logic        cfg_long_sync,
  output logic        cfg_ext_bclk,
  output logic [1:0]  cfg_sync_len,
  output logic        cfg_sync_inv,
  output logic [2:0]  cfg_aux,
  output logic        rx_fifo_clr,
  output logic        tx_fifo_clr,
  input  logic        ser_tx_in,
  input  logic        ser_rx_pin,
  output logic        ser_tx_pin,
  output logic        ser_rx_out
);
  logic [WORD_W-1:0] word_q;
  apc_word_t         f;

  apc_lane_regs #(.DATA_W(WORD_W), .SELF_CLR(CMD_MASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .be(bus_be),
    .wdata(bus_wdata), .q(word_q)
  );

  apc_read_port #(.DATA_W(WORD_W)) u_rd (
    .rd(bus_rd), .word(word_q), .rdata(bus_rdata)
  );

  assign f = apc_word_t'(word_q);

  assign cfg_async     = f.async_mode;
  assign cfg_wide      = f.wide;
  assign cfg_loop      = f.loop_en;
  assign cfg_slots     = f.slots;
  assign cfg_ext_sync  = f.ext_sync;
  assign cfg_long_sync = f.long_sync;
  assign cfg_ext_bclk  = f.ext_bclk;
  assign cfg_sync_len  = f.sync_len;
  assign cfg_sync_inv  = f.sync_inv;
  assign cfg_aux       = f.aux;
  assign rx_fifo_clr   = f.clr_rx;
  assign tx_fifo_clr   = f.clr_tx;

  apc_loop_mux u_loop (
    .loop_en(f.loop_en), .tx_in(ser_tx_in), .rx_pin(ser_rx_pin),
    .tx_pin(ser_tx_pin), .rx_out(ser_rx_out)
  );
endmodule

// File: rtl/audio_port_ctrl_chk.sv
module audio_port_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic        be_hi,
  input logic        wd_rx,
  input logic        wd_tx,
  input logic [15:0] bus_rdata,
  input logic [5:0]  hi_cfg,
  input logic        cfg_loop,
  input logic        rx_fifo_clr,
  input logic        tx_fifo_clr,
  input logic        ser_tx_in,
  input logic        ser_tx_pin,
  input logic        ser_rx_out
);
  assert_rx_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && be_hi && wd_rx) |=> rx_fifo_clr);
  assert_rx_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fifo_clr |-> $past(bus_wr && be_hi && wd_rx));
  assert_tx_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && be_hi && wd_tx) |=> tx_fifo_clr);
  assert_tx_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fifo_clr |-> $past(bus_wr && be_hi && wd_tx));
  assert_low_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !be_hi) |=> ($stable(hi_cfg) && !rx_fifo_clr && !tx_fifo_clr));
  assert_loop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_loop |-> (ser_rx_out == ser_tx_in));
  assert_tx_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ser_tx_pin == ser_tx_in);
  assert_idle_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == 16'h0000));
endmodule

bind audio_port_ctrl audio_port_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .be_hi(bus_be[1]), .wd_rx(bus_wdata[8]), .wd_tx(bus_wdata[9]),
  .bus_rdata(bus_rdata),
  .hi_cfg({cfg_aux, cfg_sync_inv, cfg_sync_len}),
  .cfg_loop(cfg_loop), .rx_fifo_clr(rx_fifo_clr), .tx_fifo_clr(tx_fifo_clr),
  .ser_tx_in(ser_tx_in), .ser_tx_pin(ser_tx_pin), .ser_rx_out(ser_rx_out)
);

// File: tb/audio_port_ctrl_tb.sv
module audio_port_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_be = 2'b00;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic cfg_async, cfg_wide, cfg_loop, cfg_ext_sync, cfg_long_sync, cfg_ext_bclk, cfg_sync_inv;
  logic [1:0] cfg_slots, cfg_sync_len;
  logic [2:0] cfg_aux;
  logic rx_fifo_clr, tx_fifo_clr;
  logic ser_tx_in = 1'b0, ser_rx_pin = 1'b0, ser_tx_pin, ser_rx_out;

  int checks = 0, failures = 0;
  logic [15:0] model = '0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  audio_port_ctrl u_dut (.*);

  function automatic logic [15:0] cfg_vec();
    return {cfg_aux, cfg_sync_inv, cfg_sync_len, 2'b00, cfg_ext_bclk,
            cfg_long_sync, cfg_ext_sync, cfg_slots, cfg_loop, cfg_wide, cfg_async};
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: mid-cycle compare of read data against queued expectations
  always @(negedge clk) begin
    if (bus_rd && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(bus_rdata, e, t);
    end
  end

  // all tasks start and end 1 ns after a rising edge
  task automatic bus_write(input logic [1:0] be, input logic [15:0] d);
    bus_wr = 1'b1; bus_be = be; bus_wdata = d;
    if (be[0]) model[7:0]  = d[7:0];
    if (be[1]) model[15:8] = {d[15:10], 2'b00};
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_be = 2'b00; bus_wdata = '0;
  endtask

  // one cycle: queue a read, check the pulse pins at mid-cycle
  task automatic cycle_check(input logic [15:0] rd_exp, input logic rx_e, input logic tx_e,
                             input string tag);
    exp_q.push_back(rd_exp); tag_q.push_back({tag, " readback"});
    bus_rd = 1'b1;
    @(negedge clk);
    check({15'd0, rx_fifo_clr}, {15'd0, rx_e}, {tag, " rx_fifo_clr"});
    check({15'd0, tx_fifo_clr}, {15'd0, tx_e}, {tag, " tx_fifo_clr"});
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic check_serial(input string tag);
    @(negedge clk);
    check({15'd0, ser_rx_out}, {15'd0, cfg_loop ? ser_tx_in : ser_rx_pin}, {tag, " R8 rx source"});
    check({15'd0, ser_tx_pin}, {15'd0, ser_tx_in}, {tag, " R9 tx pin"});
    @(posedge clk); #1;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(cfg_vec(), 16'h0000, "R1 config pins in reset");
    rst_n = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    check(cfg_vec(), 16'h0000, "R1 config pins after reset");
    check(bus_rdata, 16'h0000, "R10 idle read data");
    @(posedge clk); #1;
    cycle_check(16'h0000, 1'b0, 1'b0, "R1 reset word");

    // full-word pattern A, command bits 0 (R2 R3 R6)
    bus_write(2'b11, 16'hF4B5);
    cycle_check(model, 1'b0, 1'b0, "R6 no pulse on zero command");
    @(negedge clk);
    check(cfg_vec(), model, "R2 R3 decode pattern A");
    @(posedge clk); #1;

    // pattern B, mostly complementary
    bus_write(2'b11, 16'h084A);
    @(negedge clk);
    check(cfg_vec(), model, "R2 R3 decode pattern B");
    @(posedge clk); #1;
    cycle_check(model, 1'b0, 1'b0, "R10 read pattern B");

    // low lane only with command bits set in high data (R7)
    bus_write(2'b01, 16'hFF13);
    cycle_check(model, 1'b0, 1'b0, "R7 low-lane write");
    @(negedge clk);
    check(cfg_vec(), 16'h0813, "R7 high fields kept");
    @(posedge clk); #1;

    // high lane only with receive clear (R4 R7)
    bus_write(2'b10, 16'h3500);
    cycle_check(model | 16'h0100, 1'b1, 1'b0, "R4 rx pulse cycle");
    cycle_check(model, 1'b0, 1'b0, "R4 rx bit self-cleared");
    @(negedge clk);
    check(cfg_vec(), 16'h3413, "R7 low byte kept by high-lane write");
    @(posedge clk); #1;

    // transmit clear (R5)
    bus_write(2'b10, 16'h3600);
    cycle_check(model | 16'h0200, 1'b0, 1'b1, "R5 tx pulse cycle");
    cycle_check(model, 1'b0, 1'b0, "R5 tx bit self-cleared");

    // both at once
    bus_write(2'b11, 16'h0300);
    cycle_check(16'h0300, 1'b1, 1'b1, "R4 R5 both pulses");
    cycle_check(16'h0000, 1'b0, 1'b0, "R4 R5 both cleared");

    // loopback off then on, inputs opposite (R8 R9)
    ser_tx_in = 1'b1; ser_rx_pin = 1'b0;
    check_serial("loop off a");
    ser_tx_in = 1'b0; ser_rx_pin = 1'b1;
    check_serial("loop off b");
    bus_write(2'b01, 16'h0004);
    @(negedge clk);
    check({15'd0, cfg_loop}, 16'h0001, "R2 loop pin");
    @(posedge clk); #1;
    check_serial("loop on a");
    ser_tx_in = 1'b1; ser_rx_pin = 1'b0;
    check_serial("loop on b");
    bus_write(2'b01, 16'h0000);
    check_serial("loop off again");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule